// File: doc/BRIEF.md
# I2C Register-Pair Port Expander Target

This block is an I2C target that gives a controller access to sixteen general-purpose pins. The pins are split into two 8-bit ports. Each port has four byte registers: a pin-state view, an output latch, a polarity mask and a direction mask. That makes eight registers, reached through a 3-bit pointer that the controller loads with the first byte of every write transfer. A read is a combined transfer: the address is sent with the write flag, then the pointer byte, then a repeated START, then the address with the read flag.

Sequential accesses do not walk through the register map. Every further byte, in either direction, goes to the other register of the same pair. A read can run for any length until the controller declines to acknowledge. The pin inputs are synchronized to the system clock. Pin-state bytes are captured on the SCL falling edge that closes an acknowledge slot. An active-low interrupt goes low when an input pin differs from the value it had when its port was last read.

SCL and SDA are oversampled by the system clock. SDA is driven through an open-drain enable, so the line is pulled low whenever `sda_oe` is high.

Top module: `gpio_expander_i2c`

## Requirements
- R1: The target acknowledges, by pulling SDA low for the ninth clock, only an address whose seven bits are 0,1,0,0 followed by `addr_sel[2:0]`. A foreign address gets no acknowledge, and nothing after it is acknowledged until the next START.
- R2: The first byte after an address with R/W = 0 is the pointer and is acknowledged. Only its low three bits count: 0/1 pin state of port 0/1, 2/3 output latch, 4/5 polarity mask, 6/7 direction mask.
- R3: Each written data byte is acknowledged and stored into the pointed register. The next byte then goes to the other register of the same pair, because pointer bit 0 flips.
- R4: Bytes written to pointer codes 0 and 1 are acknowledged and discarded, and no register changes.
- R5: After a repeated START and a matching address with R/W = 1, the pointed register is sent MSB first. Each byte the controller acknowledges is followed by the other register of the pair, with no limit on length. After a byte that gets no acknowledge, SDA stays released.
- R6: A pin-state byte reads as the synchronized pin levels XOR the port's polarity mask.
- R7: The pin-state byte is captured on the SCL falling edge that ends the preceding acknowledge slot. A pin change after that edge shows up only in a later capture.
- R8: After reset the output latches and direction masks are all ones, the polarity masks are zero, `pin_oe` is all zero, `int_n` is high and SDA is released.
- R9: `pin_o` follows the output latches, and a pin's `pin_oe` is high exactly when its direction bit is 0.
- R10: `int_n` goes low while any pin whose direction bit is 1 differs from its level at the last capture of its port's pin-state byte. Capturing a port's byte clears that port's contribution. Pins whose direction bit is 0 never pull `int_n` low.
- R11: A STOP at any bit position ends the transfer, releases SDA and returns the target to idle. A byte that is cut short is not stored.
- R12: The target changes SDA to pulled-low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| addr_sel | input | 3 | Strap bits forming the low three address bits |
| pin_i | input | 16 | Pin levels, port 1 in the upper byte |
| pin_o | output | 16 | Output latch values for the pins |
| pin_oe | output | 16 | Per-pin output enable |
| int_n | output | 1 | Active-low change interrupt |

## Verification
The hardest case to reach from the ports is the capture instant of a pin-state byte. It sits on the last SCL edge of an acknowledge slot, inside a read that is already running. The stimulus issues a combined read and changes the pins only after the address acknowledge has closed. It then expects the old value in the first byte and the new value only after the read has come back to the same port. The interrupt is driven the same way: single-byte reads clear one port at a time while the other port's mismatch stays visible. The direction mask is then narrowed so that a toggling pin can be shown to have no effect.

// File: rtl/gpio_expander_i2c.sv
module gpio_expander_i2c #(
  parameter logic [3:0]  ADDR_HI = 4'b0100,
  parameter int unsigned SYNC    = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  addr_sel,
  input  logic [15:0] pin_i,
  output logic [15:0] pin_o,
  output logic [15:0] pin_oe,
  output logic        int_n
);
  localparam logic [3:0] INIT_END = 4'(SYNC + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_CMD, ST_WR, ST_RD} state_t;

  logic [SYNC-1:0] scl_p, sda_p;
  logic [15:0]     pin_p [SYNC];
  logic            scl_q, sda_q;
  logic [3:0]      init_cnt;
  state_t          state;
  logic [3:0]      bitcnt;
  logic            ackph, rw, mack;
  logic [7:0]      sh;
  logic [6:0]      tx;
  logic [2:0]      ptr, rsel;
  logic [15:0]     out_q, pol_q, cfg_q, snap, word;
  logic [7:0]      rbyte;
  logic            scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
  logic            byte_done, wr_fire, load_en, addr_hit, init_done;
  logic            in_rd, in_idle;
  logic [15:0]     pin_s, in_val;

  assign scl_s    = scl_p[SYNC-1];
  assign sda_s    = sda_p[SYNC-1];
  assign pin_s    = pin_p[SYNC-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  assign in_rd     = state == ST_RD;
  assign in_idle   = state == ST_IDLE;
  assign rsel      = in_rd ? {ptr[2:1], ~ptr[0]} : ptr;
  assign in_val    = pin_s ^ pol_q;
  assign addr_hit  = sh[7:1] == {ADDR_HI, addr_sel};
  assign byte_done = scl_fall & ~ackph & (bitcnt == 4'd8);
  assign wr_fire   = byte_done & (state == ST_WR);
  assign load_en   = scl_fall & ackph & (((state == ST_ADDR) & rw) | (in_rd & mack));
  assign init_done = init_cnt == INIT_END;

  always_comb begin
    case (rsel[2:1])
      2'd0:    word = in_val;
      2'd1:    word = out_q;
      2'd2:    word = pol_q;
      default: word = cfg_q;
    endcase
    rbyte = rsel[0] ? word[15:8] : word[7:0];
  end

  assign pin_o  = out_q;
  assign pin_oe = ~cfg_q;
  assign int_n  = ~(init_done & |((pin_s ^ snap) & cfg_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      for (int i = 0; i < SYNC; i++) pin_p[i] <= '0;
    end else begin
      scl_p    <= {scl_p[SYNC-2:0], scl_i};
      sda_p    <= {sda_p[SYNC-2:0], sda_i};
      scl_q    <= scl_s;
      sda_q    <= sda_s;
      pin_p[0] <= pin_i;
      for (int i = 1; i < SYNC; i++) pin_p[i] <= pin_p[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_cnt <= '0;
      snap     <= '0;
    end else if (!init_done) begin
      init_cnt <= init_cnt + 4'd1;
      snap     <= pin_s;
    end else if (load_en && rsel[2:1] == 2'd0) begin
      if (rsel[0]) snap[15:8] <= pin_s[15:8];
      else         snap[7:0]  <= pin_s[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      ackph  <= 1'b0;
      rw     <= 1'b0;
      mack   <= 1'b0;
      sh     <= '0;
      tx     <= '0;
      ptr    <= '0;
      sda_oe <= 1'b0;
      out_q  <= '1;
      pol_q  <= '0;
      cfg_q  <= '1;
    end else if (start_c) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      ackph  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      state  <= ST_IDLE;
      bitcnt <= '0;
      ackph  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (!in_idle) begin
      if (scl_rise) begin
        if (bitcnt != 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (!in_rd) sh <= {sh[6:0], sda_s};
        end else if (in_rd) begin
          mack <= ~sda_s;
        end
      end
      if (scl_fall) begin
        if (ackph) begin
          ackph  <= 1'b0;
          bitcnt <= '0;
          sda_oe <= 1'b0;
          case (state)
            ST_ADDR: state <= rw ? ST_RD : ST_CMD;
            ST_CMD:  state <= ST_WR;
            ST_RD:   if (!mack) state <= ST_IDLE;
            default: ;
          endcase
          if (load_en) begin
            ptr    <= rsel;
            tx     <= rbyte[6:0];
            sda_oe <= ~rbyte[7];
          end
        end else if (byte_done) begin
          ackph <= 1'b1;
          case (state)
            ST_ADDR: begin
              rw     <= sh[0];
              sda_oe <= addr_hit;
              if (!addr_hit) state <= ST_IDLE;
            end
            ST_CMD: begin
              ptr    <= sh[2:0];
              sda_oe <= 1'b1;
            end
            ST_WR: begin
              sda_oe <= 1'b1;
              ptr[0] <= ~ptr[0];
              case (ptr[2:1])
                2'd1: if (ptr[0]) out_q[15:8] <= sh; else out_q[7:0] <= sh;
                2'd2: if (ptr[0]) pol_q[15:8] <= sh; else pol_q[7:0] <= sh;
                2'd3: if (ptr[0]) cfg_q[15:8] <= sh; else cfg_q[7:0] <= sh;
                default: ;
              endcase
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (in_rd && bitcnt != 4'd0) begin
          tx     <= {tx[5:0], 1'b0};
          sda_oe <= ~tx[6];
        end
      end
    end
  end
endmodule

// File: rtl/gpio_expander_i2c_chk.sv
module gpio_expander_i2c_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        sda_oe,
  input logic        ackph,
  input logic        in_rd,
  input logic        in_idle,
  input logic        wr_fire,
  input logic [2:0]  ptr,
  input logic [47:0] regs
);
  AST_ACK_SLOT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !in_rd) |-> ackph);                                   // R1
  AST_CTRL_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd && ackph) |-> !sda_oe);                                   // R5
  AST_PAIR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rd && $past(in_rd) && !$stable(ptr)) |->
      (ptr[2:1] == $past(ptr[2:1]) && ptr[0] != $past(ptr[0])));     // R5
  AST_REG_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $past(wr_fire));                              // R3
  AST_INPUT_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_fire) && $past(ptr[2:1]) == 2'd0) |-> $stable(regs));  // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);                                            // R11
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));                                // R12
endmodule

bind gpio_expander_i2c gpio_expander_i2c_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_s   (scl_s),
  .sda_oe  (sda_oe),
  .ackph   (ackph),
  .in_rd   (in_rd),
  .in_idle (in_idle),
  .wr_fire (wr_fire),
  .ptr     (ptr),
  .regs    ({out_q, pol_q, cfg_q})
);

// File: tb/tb_gpio_expander_i2c.sv
module tb_gpio_expander_i2c;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WD_CYCLES  = 190000;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV   = {4'b0100, STRAP};
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {8'h02, 8'hA5, 8'h3C},
    {8'h03, 8'h11, 8'h22},
    {8'h04, 8'h0F, 8'hF0},
    {8'h05, 8'h81, 8'h18},
    {8'h06, 8'h00, 8'hFF},
    {8'h00, 8'h77, 8'h66}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
  logic [15:0] pins_tb = 16'hC35A;
  logic sda_oe, int_n, sda_bus;
  logic [15:0] pin_o, pin_oe;
  logic [7:0] mreg [8];
  int checks = 0, fails = 0;

  assign sda_bus = sda_m & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_expander_i2c dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_sel(STRAP), .pin_i(pins_tb), .pin_o(pin_o), .pin_oe(pin_oe), .int_n(int_n)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic logic [7:0] exp_byte(input logic [2:0] idx);
    logic [15:0] v;
    v = pins_tb ^ {mreg[5], mreg[4]};
    if (idx == 3'd0) return v[7:0];
    if (idx == 3'd1) return v[15:8];
    return mreg[idx];
  endfunction

  task automatic i2c_start();
    sda_m = 1; scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic i2c_rstart();
    sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q);
  endtask
  task automatic i2c_stop();
    sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; tick(Q); scl = 1; tick(Q); ack = !sda_bus; tick(Q); scl = 0; tick(Q);
  endtask

  task automatic recv_byte(input bit ack_m, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl = 1; tick(Q); b[i] = sda_bus; tick(Q); scl = 0;
    end
    tick(Q); sda_m = ack_m ? 1'b0 : 1'b1; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q); sda_m = 1;
  endtask

  task automatic wr_seq(input logic [7:0] cmd, input logic [7:0] d0, input logic [7:0] d1, input int n);
    bit ack;
    logic [2:0] idx;
    i2c_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R1 address ack on write", ack, 1);
    send_byte(cmd, ack);         chk(ack, "R2 pointer ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(k == 0 ? d0 : d1, ack); chk(ack, "R3 data ack", ack, 1);
      idx = cmd[2:0] ^ 3'(k & 1);
      if (idx >= 3'd2) mreg[idx] = (k == 0) ? d0 : d1;
    end
    i2c_stop(); tick(4);
  endtask

  task automatic rd_seq(input logic [7:0] cmd, input int n, input string tag);
    bit ack;
    logic [7:0] b, e;
    i2c_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R1 address ack", ack, 1);
    send_byte(cmd, ack);         chk(ack, "R2 pointer ack", ack, 1);
    i2c_rstart();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R5 read address ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      e = exp_byte(cmd[2:0] ^ 3'(k & 1));
      chk(b == e, tag, b, e);
    end
    chk(sda_oe == 1'b0, "R5 SDA released after NACK", sda_oe, 0);
    i2c_stop(); tick(4);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit ack;
    logic [7:0] b;
    logic [2:0] c;
    mreg = '{8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF};
    tick(5); rst_n = 1; tick(10);

    chk(int_n == 1'b1, "R8 int_n after reset", int_n, 1);
    chk(sda_oe == 1'b0, "R8 SDA released after reset", sda_oe, 0);
    chk(pin_oe == 16'h0000, "R8 pin_oe after reset", pin_oe, 0);
    chk(pin_o == 16'hFFFF, "R8 pin_o after reset", pin_o, 16'hFFFF);
    rd_seq(8'h06, 2, "R8 direction default");
    rd_seq(8'h04, 2, "R8 polarity default");

    i2c_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack); chk(!ack, "R1 foreign address nack", ack, 0);
    send_byte(8'h02, ack);               chk(!ack, "R1 no ack after foreign address", ack, 0);
    i2c_stop(); tick(4);
    i2c_start();
    send_byte({DEV ^ 7'h40, 1'b1}, ack); chk(!ack, "R1 upper bits mismatch nack", ack, 0);
    i2c_stop(); tick(4);

    for (int v = 0; v < NV; v++) begin
      c = VEC[v][18:16];
      wr_seq(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 2);
      rd_seq(VEC[v][23:16], 3, c < 3'd2 ? "R4 R6 write to pin state ignored" : "R3 R5 pair readback");
      chk(pin_o == {mreg[3], mreg[2]}, "R9 pin_o", pin_o, {mreg[3], mreg[2]});
      chk(pin_oe == ~{mreg[7], mreg[6]}, "R9 pin_oe", pin_oe, ~{mreg[7], mreg[6]});
    end

    wr_seq(8'hF2, 8'h6B, 8'h00, 1);
    chk(pin_o[7:0] == 8'h6B, "R2 high pointer bits ignored on write", pin_o[7:0], 8'h6B);
    rd_seq(8'hA3, 2, "R2 high pointer bits ignored on read");

    wr_seq(8'h04, 8'hFF, 8'h00, 2);
    pins_tb = 16'h00A5; tick(6);
    rd_seq(8'h00, 2, "R6 polarity applied");

    rd_seq(8'h07, 6, "R5 long alternating read");

    wr_seq(8'h04, 8'h00, 8'h00, 2);
    pins_tb = 16'h0000; tick(6);
    i2c_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h00, ack);
    i2c_rstart();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R7 read address ack", ack, 1);
    pins_tb = 16'h005A;
    recv_byte(1'b1, b); chk(b == 8'h00, "R7 captured before pin change", b, 8'h00);
    recv_byte(1'b1, b); chk(b == 8'h00, "R7 other port", b, 8'h00);
    recv_byte(1'b0, b); chk(b == 8'h5A, "R7 recaptured after ack", b, 8'h5A);
    i2c_stop(); tick(4);

    wr_seq(8'h06, 8'hFF, 8'hFF, 2);
    rd_seq(8'h00, 2, "R10 clearing read");
    tick(4);
    chk(int_n == 1'b1, "R10 idle after read", int_n, 1);
    pins_tb ^= 16'h0008; tick(6);
    chk(int_n == 1'b0, "R10 pin change asserts", int_n, 0);
    rd_seq(8'h01, 1, "R10 other port read");
    chk(int_n == 1'b0, "R10 other port read keeps low", int_n, 0);
    rd_seq(8'h00, 1, "R10 own port read");
    chk(int_n == 1'b1, "R10 own port read clears", int_n, 1);
    wr_seq(8'h06, 8'hF7, 8'h00, 1);
    pins_tb ^= 16'h0008; tick(6);
    chk(int_n == 1'b1, "R10 output pin masked", int_n, 1);
    pins_tb ^= 16'h0200; tick(6);
    chk(int_n == 1'b0, "R10 port 1 input change", int_n, 0);
    rd_seq(8'h01, 1, "R10 port 1 read");
    chk(int_n == 1'b1, "R10 port 1 read clears", int_n, 1);

    i2c_start();
    send_byte({DEV, 1'b0}, ack);
    send_bits(8'h02, 4);
    i2c_stop(); tick(4);
    chk(sda_oe == 1'b0, "R11 STOP inside pointer byte", sda_oe, 0);
    i2c_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h02, ack);
    send_bits(8'h00, 3);
    i2c_stop(); tick(4);
    chk(pin_o[7:0] == mreg[2], "R11 partial byte not stored", pin_o[7:0], mreg[2]);
    rd_seq(8'h02, 2, "R11 transfer after abort");

    summary();
    $finish;
  end
endmodule